// File: doc/BRIEF.md
# Calibrated Seconds Prescaler with Frequency-Test Output

This block turns a stream of oscillator-enable pulses, nominally 32,768 per second, into a one-cycle pulse on `sec_tick` at the end of every second. It adjusts the timebase in software-set steps so that a real crystal that runs slightly fast or slow can be trimmed. It tracks its own position inside a repeating correction cycle of minutes. In each of the first minutes of that cycle it stretches or shrinks exactly one second. The correction is applied in units of the divide-by-128 stage. A 5-bit magnitude sets how many minutes are touched, and a sign bit sets the direction.

The block also drives a square wave for production trimming. It is derived from the raw pulse stream ahead of the correction, so its rate never depends on the calibration setting. A set of control conditions gates this wave. A stop control freezes the divider and returns the correction cycle to its start.

Top module: `rtc_cal_prescaler`

## Requirements
- R1: After reset, `sec_tick` and `ft_out` are both low.
- R2: With a zero calibration magnitude, every second spans OSC_HZ clock cycles in which `osc_en` is high, and `sec_tick` is high for exactly one cycle, the cycle after the pulse that completes the second.
- R3: Only cycles with `osc_en` high advance the divider, so pulses on alternate cycles make every second last twice as many clock cycles.
- R4: When `cal_pos` is 1, a corrected second is 2*CORR_UNIT pulses shorter than OSC_HZ (256 with defaults).
- R5: When `cal_pos` is 0, a corrected second is CORR_UNIT pulses longer than OSC_HZ (128 with defaults).
- R6: With magnitude N, the corrected second is second 0 of minutes 0 through 2N-1 of the cycle. Every other second has the full OSC_HZ length.
- R7: The last two minutes of the MINS_PER_CYCLE-minute cycle are never corrected, whatever the magnitude. After the final minute the position returns to minute 0.
- R8: The block takes `cal_mag` and `cal_pos` only at a minute boundary or while `stop` is high, so a change made in mid-minute first affects the next minute.
- R9: While `stop` is high, no `sec_tick` occurs and the second and minute positions clear. The first second after release is second 0 of minute 0.
- R10: When enabled, `ft_out` toggles every OSC_HZ/(2*FT_HZ) pulses (a 512 Hz wave with defaults), and this period does not depend on the calibration value.
- R11: `ft_out` is enabled only when `stop` is 0, `ft_en` is 1, `alarm_ie` is 0, and either `wd_steer` or `wd_zero` is 1. Otherwise it is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_en | input | 1 | One pulse per oscillator period |
| cal_mag | input | CAL_W | Calibration magnitude, 0 to 31 |
| cal_pos | input | 1 | Calibration sign: 1 speeds the clock, 0 slows it |
| stop | input | 1 | Freezes the divider and clears the cycle position |
| ft_en | input | 1 | Frequency-test request |
| alarm_ie | input | 1 | Alarm interrupt enable; blocks the test wave |
| wd_steer | input | 1 | Watchdog routed to reset; allows the test wave |
| wd_zero | input | 1 | Watchdog setting is all zero; allows the test wave |
| sec_tick | output | 1 | One-cycle pulse at the end of each second |
| ft_out | output | 1 | Frequency-test square wave |

## Verification
The assertions check every cycle that a tick lasts one cycle, that it follows a counted pulse, and that it is absent while stopped. They also check that a lengthened or shortened second only ever sits at second 0 of an eligible minute, and that the test wave holds when no pulse arrives and drops when its enable conditions fail. The actual second lengths for each sign and magnitude, the cap at the last two minutes, the return to minute 0, and the deferral of a mid-minute calibration change to the next minute can only be shown by the bench. It measures the interval between ticks over whole correction cycles with reduced parameters.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    // Length of the current second relative to nominal
    typedef enum logic [1:0] {
        CORR_NONE  = 2'd0,
        CORR_SHORT = 2'd1,
        CORR_LONG  = 2'd2
    } corr_e;

    // Conditions under which the test square wave may run
    function automatic logic ft_allowed(
        input logic stop,
        input logic ft_en,
        input logic alarm_ie,
        input logic wd_steer,
        input logic wd_zero
    );
        return !stop && ft_en && !alarm_ie && (wd_steer || wd_zero);
    endfunction

endpackage

// File: rtl/rtc_cal_sched.sv
module rtc_cal_sched
    import rtc_cal_pkg::*;
#(
    parameter int CAL_W          = 5,
    parameter int SECS_PER_MIN   = 60,
    parameter int MINS_PER_CYCLE = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stop,
    input  logic             sec_wrap,
    input  logic [CAL_W-1:0] cal_mag,
    input  logic             cal_pos,
    output corr_e            corr_mode
);
    localparam int SEC_W = $clog2(SECS_PER_MIN);
    localparam int MIN_W = $clog2(MINS_PER_CYCLE);
    localparam int unsigned ELIG = MINS_PER_CYCLE - 2;

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [MIN_W-1:0] min;
        logic [CAL_W-1:0] mag;
        logic             pos;
    } sched_t;

    sched_t s_d, s_q;
    logic   last_sec, last_min, in_span;

    always_comb begin
        s_d      = s_q;
        last_sec = (s_q.sec == SEC_W'(SECS_PER_MIN - 1));
        last_min = (s_q.min == MIN_W'(MINS_PER_CYCLE - 1));
        if (stop) begin
            s_d.sec = '0;
            s_d.min = '0;
            s_d.mag = cal_mag;
            s_d.pos = cal_pos;
        end else if (sec_wrap) begin
            if (last_sec) begin
                s_d.sec = '0;
                s_d.min = last_min ? '0 : s_q.min + MIN_W'(1);
                s_d.mag = cal_mag;
                s_d.pos = cal_pos;
            end else begin
                s_d.sec = s_q.sec + SEC_W'(1);
            end
        end
        in_span = (32'(s_q.min) < 32'({s_q.mag, 1'b0})) && (32'(s_q.min) < ELIG);
        corr_mode = CORR_NONE;
        if ((s_q.sec == '0) && in_span) begin
            corr_mode = s_q.pos ? CORR_SHORT : CORR_LONG;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R6 / R7: an altered second sits only at second 0 of an eligible minute
    p_corr_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (corr_mode != CORR_NONE) |-> (s_q.sec == '0 && 32'(s_q.min) < ELIG));

    // R9: after a stop cycle the position is back at the start
    p_stop_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (s_q.sec == '0 && s_q.min == '0));

endmodule

// File: rtl/rtc_sec_divider.sv
module rtc_sec_divider
    import rtc_cal_pkg::*;
#(
    parameter int OSC_HZ    = 32768,
    parameter int CORR_UNIT = 128
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  osc_en,
    input  logic  stop,
    input  corr_e corr_mode,
    output logic  sec_wrap,
    output logic  sec_tick
);
    localparam int LIM_W = $clog2(OSC_HZ + CORR_UNIT + 1);

    typedef struct packed {
        logic [LIM_W-1:0] cnt;
        logic             tick;
    } div_t;

    div_t             d_d, d_q;
    logic [LIM_W-1:0] limit;

    always_comb begin
        case (corr_mode)
            CORR_SHORT: limit = LIM_W'(OSC_HZ - 2 * CORR_UNIT);
            CORR_LONG:  limit = LIM_W'(OSC_HZ + CORR_UNIT);
            default:    limit = LIM_W'(OSC_HZ);
        endcase
        sec_wrap = !stop && osc_en && (d_q.cnt == limit - LIM_W'(1));
        d_d      = d_q;
        d_d.tick = sec_wrap;
        if (stop || sec_wrap) d_d.cnt = '0;
        else if (osc_en)      d_d.cnt = d_q.cnt + LIM_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) d_q <= '0;
        else        d_q <= d_d;
    end

    assign sec_tick = d_q.tick;

    // R2: a tick is a single-cycle pulse
    p_tick_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |=> !sec_tick);

    // R3: a tick always follows a counted oscillator pulse
    p_tick_after_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |-> $past(osc_en));

    // R9: no tick while stopped
    p_stop_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !sec_tick);

endmodule

// File: rtl/rtc_ft_gen.sv
module rtc_ft_gen
    import rtc_cal_pkg::*;
#(
    parameter int OSC_HZ = 32768,
    parameter int FT_HZ  = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_en,
    input  logic stop,
    input  logic ft_en,
    input  logic alarm_ie,
    input  logic wd_steer,
    input  logic wd_zero,
    output logic ft_out
);
    localparam int HALF = OSC_HZ / (2 * FT_HZ);
    localparam int FT_W = $clog2(HALF + 1);

    typedef struct packed {
        logic [FT_W-1:0] cnt;
        logic            wave;
    } ft_t;

    ft_t  f_d, f_q;
    logic run;

    always_comb begin
        run = ft_allowed(stop, ft_en, alarm_ie, wd_steer, wd_zero);
        f_d = f_q;
        if (!run) begin
            f_d.cnt  = '0;
            f_d.wave = 1'b0;
        end else if (osc_en) begin
            if (f_q.cnt == FT_W'(HALF - 1)) begin
                f_d.cnt  = '0;
                f_d.wave = !f_q.wave;
            end else begin
                f_d.cnt = f_q.cnt + FT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign ft_out = f_q.wave;

    // R11: a disabled test wave reads low on the next cycle
    p_ft_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !ft_out);

    // R10: without an oscillator pulse the wave does not move
    p_ft_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !osc_en) |=> $stable(ft_out));

endmodule

// File: rtl/rtc_cal_prescaler.sv
module rtc_cal_prescaler
    import rtc_cal_pkg::*;
#(
    parameter int OSC_HZ         = 32768,
    parameter int CORR_UNIT      = 128,
    parameter int CAL_W          = 5,
    parameter int SECS_PER_MIN   = 60,
    parameter int MINS_PER_CYCLE = 64,
    parameter int FT_HZ          = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_en,
    input  logic [CAL_W-1:0] cal_mag,
    input  logic             cal_pos,
    input  logic             stop,
    input  logic             ft_en,
    input  logic             alarm_ie,
    input  logic             wd_steer,
    input  logic             wd_zero,
    output logic             sec_tick,
    output logic             ft_out
);
    corr_e corr_mode;
    logic  sec_wrap;

    rtc_cal_sched #(
        .CAL_W          (CAL_W),
        .SECS_PER_MIN   (SECS_PER_MIN),
        .MINS_PER_CYCLE (MINS_PER_CYCLE)
    ) i_sched (
        .clk       (clk),
        .rst_n     (rst_n),
        .stop      (stop),
        .sec_wrap  (sec_wrap),
        .cal_mag   (cal_mag),
        .cal_pos   (cal_pos),
        .corr_mode (corr_mode)
    );

    rtc_sec_divider #(
        .OSC_HZ    (OSC_HZ),
        .CORR_UNIT (CORR_UNIT)
    ) i_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .osc_en    (osc_en),
        .stop      (stop),
        .corr_mode (corr_mode),
        .sec_wrap  (sec_wrap),
        .sec_tick  (sec_tick)
    );

    rtc_ft_gen #(
        .OSC_HZ (OSC_HZ),
        .FT_HZ  (FT_HZ)
    ) i_ft (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_en   (osc_en),
        .stop     (stop),
        .ft_en    (ft_en),
        .alarm_ie (alarm_ie),
        .wd_steer (wd_steer),
        .wd_zero  (wd_zero),
        .ft_out   (ft_out)
    );

endmodule

// File: tb/test_rtc_cal_prescaler.sv
`timescale 1ns/1ps
module test_rtc_cal_prescaler;
    localparam int B_OSC  = 1024;
    localparam int B_UNIT = 8;
    localparam int B_SPM  = 4;
    localparam int B_MPC  = 8;
    localparam int B_FT   = 32;
    localparam int B_HALF = B_OSC / (2 * B_FT);

    typedef struct packed {
        logic [4:0] mag;
        logic       pos;
        logic [7:0] nsec;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{mag: 5'd0,  pos: 1'b0, nsec: 8'd8},
        '{mag: 5'd1,  pos: 1'b1, nsec: 8'd12},
        '{mag: 5'd1,  pos: 1'b0, nsec: 8'd12},
        '{mag: 5'd2,  pos: 1'b1, nsec: 8'd12},
        '{mag: 5'd31, pos: 1'b0, nsec: 8'd36}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_en = 1'b1;
    logic [4:0] cal_mag = '0;
    logic       cal_pos = 1'b0;
    logic       stop = 1'b1;
    logic       ft_en = 1'b0;
    logic       alarm_ie = 1'b0;
    logic       wd_steer = 1'b0;
    logic       wd_zero = 1'b0;
    logic       sec_tick, ft_out;
    logic       half_rate = 1'b0;
    int         vec_cnt = 0;
    int         bad_cnt = 0;

    always #10 clk = ~clk;

    always @(negedge clk) osc_en <= half_rate ? ~osc_en : 1'b1;

    rtc_cal_prescaler #(
        .OSC_HZ (B_OSC), .CORR_UNIT (B_UNIT), .CAL_W (5),
        .SECS_PER_MIN (B_SPM), .MINS_PER_CYCLE (B_MPC), .FT_HZ (B_FT)
    ) i_rtc_cal_prescaler (
        .clk (clk), .rst_n (rst_n), .osc_en (osc_en), .cal_mag (cal_mag),
        .cal_pos (cal_pos), .stop (stop), .ft_en (ft_en), .alarm_ie (alarm_ie),
        .wd_steer (wd_steer), .wd_zero (wd_zero), .sec_tick (sec_tick), .ft_out (ft_out)
    );

    task automatic check(input string tag, input int act, input int exp);
        vec_cnt++;
        if (act != exp) begin
            bad_cnt++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int exp_len(input int mag, input bit pos, input int idx);
        int sec;
        int mn;
        sec = idx % B_SPM;
        mn  = (idx / B_SPM) % B_MPC;
        if (sec == 0 && mn < 2 * mag && mn < B_MPC - 2)
            return pos ? B_OSC - 2 * B_UNIT : B_OSC + B_UNIT;
        return B_OSC;
    endfunction

    function automatic string exp_tag(input int mag, input bit pos, input int idx);
        int sec;
        int mn;
        sec = idx % B_SPM;
        mn  = (idx / B_SPM) % B_MPC;
        if (mag == 0) return "R2";
        if (exp_len(mag, pos, idx) != B_OSC) return pos ? "R4" : "R5";
        if (mn >= B_MPC - 2) return "R7";
        return "R6";
    endfunction

    // Counts clock cycles until the next tick, sampled on falling edges
    task automatic wait_tick(output int n);
        n = 0;
        forever begin
            @(negedge clk);
            n++;
            if (sec_tick) break;
            if (n > 3 * B_OSC) break;
        end
    endtask

    task automatic restart(input int mag, input bit pos);
        @(negedge clk);
        stop    = 1'b1;
        cal_mag = 5'(mag);
        cal_pos = pos;
        @(negedge clk);
        @(negedge clk);
        stop = 1'b0;
    endtask

    // Counts cycles between changes of the test wave
    task automatic wait_ft_edge(output int n);
        logic prev;
        prev = ft_out;
        n = 0;
        forever begin
            @(negedge clk);
            n++;
            if (ft_out != prev) break;
            if (n > 8 * B_HALF) break;
        end
    endtask

    task automatic ft_quiet(input string tag);
        int highs;
        highs = 0;
        @(negedge clk);
        @(negedge clk);
        for (int k = 0; k < 4 * B_HALF; k++) begin
            @(negedge clk);
            if (ft_out) highs++;
        end
        check(tag, highs, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad_cnt++;
        $display("FAIL R2 watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
        $finish;
    end

    initial begin
        int n;
        int ticks;
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 tick at reset", int'(sec_tick), 0);
        check("R1 ft at reset", int'(ft_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 tick after reset", int'(sec_tick), 0);
        check("R1 ft after reset", int'(ft_out), 0);

        // Table walk: second lengths per magnitude and sign (R2, R4..R7)
        foreach (VECS[v]) begin
            restart(int'(VECS[v].mag), VECS[v].pos);
            for (int s = 0; s < int'(VECS[v].nsec); s++) begin
                wait_tick(n);
                check(exp_tag(int'(VECS[v].mag), VECS[v].pos, s), n,
                      exp_len(int'(VECS[v].mag), VECS[v].pos, s));
            end
        end

        // R8: change made during minute 0 waits for minute 1
        restart(0, 1'b0);
        fork
            begin
                repeat (10) @(negedge clk);
                cal_mag = 5'd1;
                cal_pos = 1'b1;
            end
        join_none
        for (int s = 0; s < 9; s++) begin
            wait_tick(n);
            check("R8 deferred calibration", n, (s < B_SPM) ? B_OSC : exp_len(1, 1'b1, s));
        end

        // R9: stop holds off ticks, then restarts at minute 0 second 0
        repeat (B_OSC / 2) @(negedge clk);
        stop = 1'b1;
        ticks = 0;
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            if (sec_tick) ticks++;
        end
        check("R9 ticks while stopped", ticks, 0);
        stop = 1'b0;
        for (int s = 0; s < 5; s++) begin
            wait_tick(n);
            check("R9 restart position", n, exp_len(1, 1'b1, s));
        end

        // R3: pulses on alternate cycles double the second
        restart(0, 1'b0);
        half_rate = 1'b1;
        wait_tick(n);
        wait_tick(n);
        check("R3 half-rate second", n, 2 * B_OSC);
        half_rate = 1'b0;
        @(negedge clk);

        // R10: test wave period, independent of calibration
        restart(0, 1'b0);
        ft_en = 1'b1;
        wd_steer = 1'b1;
        for (int k = 0; k < 3; k++) begin
            wait_ft_edge(n);
            check("R10 ft half period", n, B_HALF);
        end
        cal_mag = 5'd31;
        cal_pos = 1'b1;
        for (int k = 0; k < 3; k++) begin
            wait_ft_edge(n);
            check("R10 ft half period after calibration change", n, B_HALF);
        end
        wd_steer = 1'b0;
        wd_zero  = 1'b1;
        @(negedge clk);
        wait_ft_edge(n);
        wait_ft_edge(n);
        check("R10 ft runs with zero watchdog", n, B_HALF);

        // R11: each blocking condition holds the wave low
        ft_en = 1'b0;
        ft_quiet("R11 ft_en low");
        ft_en = 1'b1;
        alarm_ie = 1'b1;
        ft_quiet("R11 alarm enable set");
        alarm_ie = 1'b0;
        wd_zero = 1'b0;
        ft_quiet("R11 steering and zero both low");
        wd_zero = 1'b1;
        stop = 1'b1;
        ft_quiet("R11 stopped");

        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
        $finish;
    end
endmodule